// File: doc/BRIEF.md
# Iterative Multiply and Divide Unit

This unit executes the two long-running arithmetic operations of an 8-bit accumulator CPU: an unsigned 8x8 multiply and an unsigned 16-by-8 divide. The surrounding core hands over its current accumulator (A), index low byte (X) and index high byte (H), picks the operation with a one-bit select, and pulses a start strobe. A fixed number of clocks later the unit returns the new A, X and H values and the flag updates, together with a single-cycle done pulse.

The multiply uses a shift-and-add datapath and the divide uses a restoring datapath. Both retire a configurable number of bits per clock. The result always lands in the same registers. For a multiply, the product high byte goes to X and the low byte to A, and H passes through. For a divide, the quotient goes to A and the remainder to H, and X is returned as it was given. Each flag output has its own write enable, so the core can leave the flags that an operation does not touch untouched.

Top module: `muldiv_unit`

## Requirements
- R1: With op_i = 0 (multiply), the returned x_o:a_o equals the unsigned product x_i * a_i, with the high byte in x_o and the low byte in a_o. h_o returns h_i.
- R2: A multiply raises carry_we_o and half_we_o with carry_o = 0 and half_o = 0, and holds zero_we_o low.
- R3: A multiply raises done_o exactly 5 rising edges after the edge that accepts start_i.
- R4: With op_i = 1 (divide), x_i != 0 and h_i < x_i, a_o is the quotient and h_o the remainder of the dividend {h_i, a_i} divided by x_i.
- R5: A divide returns x_o equal to x_i.
- R6: A divide raises carry_we_o with carry_o = 1 exactly when x_i = 0 or h_i >= x_i (the quotient does not fit in 8 bits), and carry_o = 0 otherwise. half_we_o stays low. A and H are then deterministic but unspecified, and done_o still asserts.
- R7: A divide raises zero_we_o with zero_o = 1 exactly when the returned a_o is 0.
- R8: A divide raises done_o exactly 7 rising edges after the edge that accepts start_i.
- R9: start_i asserted while an operation is in flight is ignored. It neither changes that operation's result or timing nor produces a second done.
- R10: done_o is high for one cycle per accepted start, and all flag write enables are low whenever done_o is low. After reset, done_o is low and a_o, x_o and h_o read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| op_i | input | 1 | 0 = multiply, 1 = divide |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | Index low byte value |
| h_i | input | 8 | Index high byte value |
| a_o | output | 8 | New accumulator value |
| x_o | output | 8 | New index low byte value |
| h_o | output | 8 | New index high byte value |
| carry_o | output | 1 | Carry flag value |
| carry_we_o | output | 1 | Carry flag write enable |
| zero_o | output | 1 | Zero flag value |
| zero_we_o | output | 1 | Zero flag write enable |
| half_o | output | 1 | Half-carry flag value |
| half_we_o | output | 1 | Half-carry flag write enable |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The assertions check, on every completion, the product value, the quotient and remainder identity, the preserved X, the carry and zero rules and the flag enables. They also check that completion lands at exactly the multiply or divide latency counted from the accepted start, and that done is a one-cycle pulse. The bench scenarios cover what those checks cannot show directly: the reset values, the corner operands (full-scale product, quotient of 0xFF, zero divisor, oversized dividend), and a second start issued during a busy operation that leaves the first result and its timing intact.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} op_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int MUL_LAT   = 5,
  parameter int DIV_LAT   = 7,
  parameter int MUL_STEPS = 4,
  parameter int DIV_STEPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic op_i,
  output logic load_o,
  output logic step_o,
  output logic op_o,
  output logic done_o
);
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int LW      = $clog2(MAX_LAT + 1);
  localparam int MAX_ST  = (MUL_STEPS > DIV_STEPS) ? MUL_STEPS : DIV_STEPS;
  localparam int SW      = $clog2(MAX_ST + 1);

  logic          busy_q;
  logic          op_q;
  logic          done_q;
  logic [LW-1:0] lat_q;
  logic [SW-1:0] iter_q;

  assign load_o = start_i && !busy_q;
  assign step_o = busy_q && (iter_q != '0);
  assign op_o   = op_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= 1'b0;
      done_q <= 1'b0;
      lat_q  <= '0;
      iter_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          op_q   <= op_i;
          lat_q  <= op_i ? LW'(DIV_LAT - 1) : LW'(MUL_LAT - 1);
          iter_q <= op_i ? SW'(DIV_STEPS) : SW'(MUL_STEPS);
        end
      end else begin
        if (iter_q != '0) iter_q <= iter_q - 1'b1;
        if (lat_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          lat_q <= lat_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int W    = 8,
  parameter int BITS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic [W-1:0] hi_q, lo_q, mcand_q;
  logic [W-1:0] hi_n, lo_n;

  // BITS shift-and-add iterations per clock
  always_comb begin
    logic [W:0] sum;
    hi_n = hi_q;
    lo_n = lo_q;
    for (int k = 0; k < BITS; k++) begin
      sum  = {1'b0, hi_n} + (lo_n[0] ? {1'b0, mcand_q} : '0);
      lo_n = {sum[0], lo_n[W-1:1]};
      hi_n = sum[W:1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
    end else if (load_i) begin
      hi_q    <= '0;
      lo_q    <= a_i;
      mcand_q <= x_i;
    end else if (step_i) begin
      hi_q <= hi_n;
      lo_q <= lo_n;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int W    = 8,
  parameter int BITS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] h_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dvs_o,
  output logic         ovf_o
);
  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic         ovf_q;
  logic [W-1:0] rem_n, quo_n;

  // BITS restoring iterations per clock; rem stays below dvs when no overflow
  always_comb begin
    logic [W:0] trial;
    rem_n = rem_q;
    quo_n = quo_q;
    for (int k = 0; k < BITS; k++) begin
      trial = {rem_n, quo_n[W-1]};
      quo_n = {quo_n[W-2:0], 1'b0};
      if (trial >= {1'b0, dvs_q}) begin
        trial    = trial - {1'b0, dvs_q};
        quo_n[0] = 1'b1;
      end
      rem_n = trial[W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= h_i;
      quo_q <= a_i;
      dvs_q <= x_i;
      ovf_q <= (x_i == '0) || (h_i >= x_i);
    end else if (step_i) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign dvs_o = dvs_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int DATA_W   = 8,
  parameter int MUL_LAT  = 5,
  parameter int DIV_LAT  = 7,
  parameter int MUL_BITS = 2,
  parameter int DIV_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] h_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] x_o,
  output logic [DATA_W-1:0] h_o,
  output logic              carry_o,
  output logic              carry_we_o,
  output logic              zero_o,
  output logic              zero_we_o,
  output logic              half_o,
  output logic              half_we_o,
  output logic              done_o
);
  import muldiv_pkg::*;

  localparam int MUL_STEPS = (DATA_W + MUL_BITS - 1) / MUL_BITS;
  localparam int DIV_STEPS = (DATA_W + DIV_BITS - 1) / DIV_BITS;

  logic              load, step, op_q, done;
  logic              mul_step, div_step, ovf;
  logic [DATA_W-1:0] mul_hi, mul_lo, quo, rem, dvs;

  muldiv_ctrl #(
    .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
    .MUL_STEPS(MUL_STEPS), .DIV_STEPS(DIV_STEPS)
  ) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .load_o(load), .step_o(step), .op_o(op_q), .done_o(done)
  );

  // both cores load; only the selected one iterates
  assign mul_step = step && (op_e'(op_q) == OP_MUL);
  assign div_step = step && (op_e'(op_q) == OP_DIV);

  muldiv_mul_core #(.W(DATA_W), .BITS(MUL_BITS)) i_mul (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(mul_step),
    .a_i(a_i), .x_i(x_i), .hi_o(mul_hi), .lo_o(mul_lo)
  );

  muldiv_div_core #(.W(DATA_W), .BITS(DIV_BITS)) i_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(div_step),
    .h_i(h_i), .a_i(a_i), .x_i(x_i),
    .quo_o(quo), .rem_o(rem), .dvs_o(dvs), .ovf_o(ovf)
  );

  // idle div core holds H and X untouched during a multiply
  assign a_o        = op_q ? quo : mul_lo;
  assign x_o        = op_q ? dvs : mul_hi;
  assign h_o        = rem;
  assign carry_o    = op_q & ovf;
  assign carry_we_o = done;
  assign zero_o     = (quo == '0);
  assign zero_we_o  = done & op_q;
  assign half_o     = 1'b0;
  assign half_we_o  = done & ~op_q;
  assign done_o     = done;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int DATA_W  = 8,
  parameter int MUL_LAT = 5,
  parameter int DIV_LAT = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] h_i,
  input logic [DATA_W-1:0] a_o,
  input logic [DATA_W-1:0] x_o,
  input logic [DATA_W-1:0] h_o,
  input logic              carry_o,
  input logic              carry_we_o,
  input logic              zero_o,
  input logic              zero_we_o,
  input logic              half_o,
  input logic              half_we_o,
  input logic              done_o
);
  localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
  localparam int CW      = $clog2(MAX_LAT + 2) + 1;

  logic              busy_c, op_c, accept;
  logic [CW-1:0]     cnt_c;
  logic [DATA_W-1:0] a_c, x_c, h_c;
  logic              fits;

  assign accept = start_i && (!busy_c || done_o);
  assign fits   = (x_c != '0) && (h_c < x_c);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_c <= 1'b0;
      op_c   <= 1'b0;
      cnt_c  <= '0;
      a_c    <= '0;
      x_c    <= '0;
      h_c    <= '0;
    end else if (accept) begin
      busy_c <= 1'b1;
      op_c   <= op_i;
      cnt_c  <= '0;
      a_c    <= a_i;
      x_c    <= x_i;
      h_c    <= h_i;
    end else begin
      if (done_o) busy_c <= 1'b0;
      if (busy_c && !done_o && cnt_c != '1) cnt_c <= cnt_c + 1'b1;
    end
  end

  a_r1_mul_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !op_c |-> ({x_o, a_o} == x_c * a_c) && (h_o == h_c));
  a_r2_mul_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !op_c |-> carry_we_o && !carry_o && half_we_o && !half_o && !zero_we_o);
  a_r3_mul_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !op_c |-> cnt_c == CW'(MUL_LAT));
  a_r4_div_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_c && fits |->
      ({h_c, a_c} == (2*DATA_W)'(a_o * x_c) + (2*DATA_W)'(h_o)) && (h_o < x_c));
  a_r5_div_keeps_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_c |-> x_o == x_c);
  a_r6_div_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_c |-> carry_we_o && (carry_o == !fits) && !half_we_o);
  a_r7_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_c |-> zero_we_o && (zero_o == (a_o == '0)));
  a_r8_div_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && op_c |-> cnt_c == CW'(DIV_LAT));
  a_r9_done_only_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_c);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_we_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !carry_we_o && !zero_we_o && !half_we_o);
endmodule

bind muldiv_unit muldiv_chk #(
  .DATA_W(DATA_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)
) i_muldiv_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
  .a_i(a_i), .x_i(x_i), .h_i(h_i), .a_o(a_o), .x_o(x_o), .h_o(h_o),
  .carry_o(carry_o), .carry_we_o(carry_we_o), .zero_o(zero_o),
  .zero_we_o(zero_we_o), .half_o(half_o), .half_we_o(half_we_o),
  .done_o(done_o)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       op_i = 1'b0;
  logic [7:0] a_i = '0, x_i = '0, h_i = '0;
  logic [7:0] a_o, x_o, h_o;
  logic       carry_o, carry_we_o, zero_o, zero_we_o, half_o, half_we_o, done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  muldiv_unit i_muldiv_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .h_i(h_i), .a_o(a_o), .x_o(x_o), .h_o(h_o),
    .carry_o(carry_o), .carry_we_o(carry_we_o), .zero_o(zero_o),
    .zero_we_o(zero_we_o), .half_o(half_o), .half_we_o(half_we_o),
    .done_o(done_o)
  );

  typedef struct packed {
    logic       op;
    logic [7:0] a, x, h;
    logic [7:0] ea, ex, eh;
    logic       ec, ez, exact;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h34, 8'h12, 8'h55, 8'hA8, 8'h03, 8'h55, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'hFF, 8'hFF, 8'h00, 8'h01, 8'hFE, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h7F, 8'h00, 8'hC3, 8'h00, 8'h00, 8'hC3, 1'b0, 1'b0, 1'b1},
    '{1'b0, 8'h02, 8'h80, 8'h01, 8'h00, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h00, 8'h10, 8'h01, 8'h10, 8'h10, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h05, 8'h07, 8'h00, 8'h00, 8'h07, 8'h05, 1'b0, 1'b1, 1'b1},
    '{1'b1, 8'h34, 8'h56, 8'h12, 8'h36, 8'h56, 8'h10, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'hFF, 8'h01, 8'h00, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'hFF, 8'hFF, 8'hFE, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b0, 1'b1},
    '{1'b1, 8'h00, 8'h10, 8'h20, 8'h00, 8'h10, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Pulse start at a falling edge, return number of rising edges after the
  // accepting edge until done_o is seen (sampled at falling edges).
  task automatic run_op(input logic op, input logic [7:0] a, x, h, output int lat);
    @(negedge clk_i);
    op_i = op; a_i = a; x_i = x; h_i = h; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(!done_o && a_o == 0 && x_o == 0 && h_o == 0, "R10", "reset state",
          {7'b0, done_o, a_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run_op(v.op, v.a, v.x, v.h, lat);
      if (!v.op) begin
        check(lat == 5, "R3", "mul latency", 16'(lat), 16'd5);
        check({x_o, a_o} == {v.ex, v.ea}, "R1", "mul product", {x_o, a_o}, {v.ex, v.ea});
        check(h_o == v.eh, "R1", "mul H passthrough", {8'h0, h_o}, {8'h0, v.eh});
        check(carry_we_o && !carry_o && half_we_o && !half_o && !zero_we_o, "R2",
              "mul flags", {11'b0, carry_we_o, carry_o, half_we_o, half_o, zero_we_o},
              16'b10100);
      end else begin
        check(lat == 7, "R8", "div latency", 16'(lat), 16'd7);
        check(x_o == v.ex, "R5", "div X kept", {8'h0, x_o}, {8'h0, v.ex});
        check(carry_we_o && carry_o == v.ec && !half_we_o, "R6", "div carry",
              {14'b0, carry_we_o, carry_o}, {14'b0, 1'b1, v.ec});
        if (v.exact) begin
          check({a_o, h_o} == {v.ea, v.eh}, "R4", "div quotient:remainder",
                {a_o, h_o}, {v.ea, v.eh});
          check(zero_we_o && zero_o == v.ez, "R7", "div zero flag",
                {14'b0, zero_we_o, zero_o}, {14'b0, 1'b1, v.ez});
        end else begin
          check(zero_we_o && zero_o == (a_o == 0), "R7", "div zero on overflow",
                {14'b0, zero_we_o, zero_o}, {14'b0, 1'b1, a_o == 0});
        end
      end
      // R10 single-cycle pulse
      @(negedge clk_i);
      check(!done_o && !carry_we_o && !zero_we_o && !half_we_o, "R10", "done pulse",
            {15'b0, done_o}, 16'h0);
    end

    // R9: second start during a busy multiply is ignored
    begin
      int edges;
      int dones;
      @(negedge clk_i);
      op_i = 1'b0; a_i = 8'h0B; x_i = 8'h0D; h_i = 8'h44; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      @(negedge clk_i);
      op_i = 1'b1; a_i = 8'h99; x_i = 8'h03; h_i = 8'h01; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      edges = 2;
      while (!done_o && edges < 40) begin
        @(negedge clk_i);
        edges++;
      end
      check(edges == 5, "R9", "latency unchanged by busy start", 16'(edges), 16'd5);
      check({x_o, a_o} == 16'h008F && h_o == 8'h44, "R9", "busy start ignored",
            {x_o, a_o}, 16'h008F);
      dones = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk_i);
        if (done_o) dones++;
      end
      check(dones == 0, "R9", "no second done", 16'(dones), 16'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule